// File: doc/BRIEF.md
# Frame-Size-Adaptive Word FIFO Pair

This block holds the transmit and receive word queues that sit between a register interface and a serial transfer engine. Each direction keeps a 32-entry physical ring of 32-bit words. The number of entries a direction may actually use changes at run time. It depends on a deep-queue enable input and on the configured frame width in bits. Narrow frames get deep queues, wide frames get shallow ones, and with deep mode off every queue is four entries.

The register side writes transmit words and reads receive words through push and pop strobes. The serial side does the reverse. Both sides see occupancy counts and a packed status bus. The status bus reports empty, almost-full and full for each direction, and a sticky receive-overflow bit. The overflow bit is cleared by any receive read. A raw overflow interrupt bit stays set until it is explicitly cleared. Each direction can be emptied by its own clear strobe.

Top module: `adaptive_word_fifo_pair`

## Requirements
- R1: With `deep_en`=1 the usable depth is 32 for `frame_bits` 0..8, 16 for 9..16, and 8 for 17 and above.
- R2: With `deep_en`=0 the usable depth is 4 for every frame width.
- R3: A transmit push while `tx_level` is at or above the usable depth is dropped. The level and the stored words are unchanged.
- R4: Status bit 1 (tx) / bit 4 (rx) is almost-full and is 1 exactly when level equals depth-1. Bit 2 (tx) / bit 5 (rx) is full and is 1 when level is at or above depth.
- R5: Status bit 0 (tx) / bit 3 (rx) is empty and is 1 exactly when level is 0. An accepted push clears it. A pop that removes the last word sets it.
- R6: A receive push while `rx_level` is at or above depth drops the word. It sets status bit 6 (overflow) and bit 7 (raw overflow interrupt) one cycle later.
- R7: Any `rx_pop`, even on an empty queue, clears status bit 6. Bit 7 stays set until `ovf_irq_clr` is pulsed. A new overflow in the same cycle wins over either clear.
- R8: `tx_clr` / `rx_clr` empties that direction in one cycle. The level goes to 0, empty goes to 1 and full goes to 0. A push or pop in the same cycle is ignored.
- R9: The read-data output is 0 while a queue is empty. A pop on an empty queue leaves its level at 0.
- R10: Changing `deep_en` or `frame_bits` while words are held keeps them. They are read back in push order, even when the level now exceeds the new depth.
- R11: After reset both levels are 0 and the status bus reads 8'h09.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_en | input | 1 | Enables frame-width-dependent deep queues |
| frame_bits | input | 6 | Configured frame width in bits |
| tx_push | input | 1 | Register side writes `tx_wdata` |
| tx_wdata | input | 32 | Transmit word to store |
| tx_pop | input | 1 | Serial side consumes the transmit head |
| tx_rdata | output | 32 | Transmit head word (0 when empty) |
| tx_clr | input | 1 | Empties the transmit queue |
| rx_push | input | 1 | Serial side delivers `rx_wdata` |
| rx_wdata | input | 32 | Received word to store |
| rx_pop | input | 1 | Register side reads the receive head |
| rx_rdata | output | 32 | Receive head word (0 when empty) |
| rx_clr | input | 1 | Empties the receive queue |
| ovf_irq_clr | input | 1 | Clears the raw overflow interrupt bit |
| tx_level | output | 6 | Transmit occupancy |
| rx_level | output | 6 | Receive occupancy |
| status | output | 8 | Packed flags: bit layout per R4-R7 |

## Verification
The in-RTL assertions check the following on every cycle:
- a dropped push never moves the level;
- a clear always leaves a queue empty;
- an empty pop leaves the level at zero;
- an overflow is always followed by both sticky bits;
- the selected depth is always a single power of two within physical capacity.

Some behaviours only the bench scenarios can show:
- the exact depth chosen for each frame-width band;
- the order and values of words read back after drops;
- the survival of stored words across a depth change;
- the separate clearing of the overflow status bit and the interrupt bit.

// File: rtl/awf_pkg.sv
package awf_pkg;

   localparam int unsigned STATUS_W = 8;

   typedef struct packed {
      logic ovf_irq;    // bit 7
      logic rx_ovf;     // bit 6
      logic rx_full;    // bit 5
      logic rx_afull;   // bit 4
      logic rx_empty;   // bit 3
      logic tx_full;    // bit 2
      logic tx_afull;   // bit 1
      logic tx_empty;   // bit 0
   } awf_status_t;

endpackage

// File: rtl/awf_depth_sel.sv
module awf_depth_sel #(
   parameter int unsigned FRAME_W       = 6,
   parameter int unsigned CNT_W         = 6,
   parameter int unsigned PHYS_DEPTH    = 32,
   parameter int unsigned SHALLOW_DEPTH = 4,
   parameter int unsigned NARROW_MAX    = 8,
   parameter int unsigned MID_MAX       = 16,
   parameter int unsigned NARROW_DEPTH  = 32,
   parameter int unsigned MID_DEPTH     = 16,
   parameter int unsigned WIDE_DEPTH    = 8
) (
   input  logic               deep_en,
   input  logic [FRAME_W-1:0] frame_bits,
   output logic [CNT_W-1:0]   depth
);

   localparam logic [FRAME_W-1:0] NARROW_LIM = FRAME_W'(NARROW_MAX);
   localparam logic [FRAME_W-1:0] MID_LIM    = FRAME_W'(MID_MAX);

   if (NARROW_DEPTH > PHYS_DEPTH || MID_DEPTH > PHYS_DEPTH ||
       WIDE_DEPTH > PHYS_DEPTH || SHALLOW_DEPTH > PHYS_DEPTH) begin : g_bad_depth
      $error("awf_depth_sel: a usable depth exceeds physical capacity");
   end
   if (NARROW_MAX >= MID_MAX) begin : g_bad_bands
      $error("awf_depth_sel: frame-width bands out of order");
   end

   always_comb begin
      if (!deep_en)                     depth = CNT_W'(SHALLOW_DEPTH);
      else if (frame_bits <= NARROW_LIM) depth = CNT_W'(NARROW_DEPTH);
      else if (frame_bits <= MID_LIM)    depth = CNT_W'(MID_DEPTH);
      else                               depth = CNT_W'(WIDE_DEPTH);
   end

   // R1 R2: the chosen depth is always one power of two, never zero
   always_comb begin
      p_depth_onehot_r1: assert ($countones(depth) == 1 || $isunknown(depth));
   end

endmodule

// File: rtl/awf_ring.sv
module awf_ring #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PHYS_DEPTH = 32,
   parameter bit          TRACK_OVF  = 1'b0,
   localparam int unsigned PTR_W     = $clog2(PHYS_DEPTH),
   localparam int unsigned CNT_W     = $clog2(PHYS_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [CNT_W-1:0]  depth,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  level,
   output logic              empty,
   output logic              afull,
   output logic              full,
   output logic              drop,
   output logic              ovf
);

   if ((1 << PTR_W) != PHYS_DEPTH) begin : g_bad_phys
      $error("awf_ring: PHYS_DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] mem [PHYS_DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              acc_push, acc_pop;

   assign acc_push = push && !clr && (level < depth);
   assign acc_pop  = pop  && !clr && (level != '0);
   assign drop     = push && !clr && !(level < depth);

   always_ff @(posedge clk) begin
      if (acc_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (acc_push) wr_ptr <= wr_ptr + 1'b1;
         if (acc_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({acc_push, acc_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign rdata = (level == '0) ? '0 : mem[rd_ptr];
   assign empty = (level == '0);
   assign full  = (level >= depth);
   assign afull = (level == depth - 1'b1);

   if (TRACK_OVF) begin : g_ovf
      logic ovf_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ovf_q <= 1'b0;
         else if (drop) ovf_q <= 1'b1;
         else if (pop)  ovf_q <= 1'b0;
      end
      assign ovf = ovf_q;

      // R6: a dropped receive word always raises the overflow flag
      p_drop_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
         drop |=> ovf);
      // R7: a read with no new drop clears the overflow flag
      p_pop_clears_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (pop && !drop) |=> !ovf);
   end else begin : g_no_ovf
      assign ovf = 1'b0;
   end

   // R3: a rejected push never changes occupancy
   p_drop_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !pop) |=> (level == $past(level)));
   // R8: clear always leaves the ring empty
   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));
   // R9: an empty pop leaves the ring empty
   p_empty_pop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (level == '0));
   // R5: an accepted push always clears empty
   p_push_clears_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr && !full) |=> !empty);
   p_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(PHYS_DEPTH));

endmodule

// File: rtl/adaptive_word_fifo_pair.sv
module adaptive_word_fifo_pair
   import awf_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned PHYS_DEPTH    = 32,
   parameter int unsigned FRAME_W       = 6,
   parameter int unsigned SHALLOW_DEPTH = 4,
   parameter int unsigned NARROW_MAX    = 8,
   parameter int unsigned MID_MAX       = 16,
   parameter int unsigned NARROW_DEPTH  = 32,
   parameter int unsigned MID_DEPTH     = 16,
   parameter int unsigned WIDE_DEPTH    = 8,
   localparam int unsigned CNT_W        = $clog2(PHYS_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               deep_en,
   input  logic [FRAME_W-1:0] frame_bits,
   input  logic               tx_push,
   input  logic [DATA_W-1:0]  tx_wdata,
   input  logic               tx_pop,
   output logic [DATA_W-1:0]  tx_rdata,
   input  logic               tx_clr,
   input  logic               rx_push,
   input  logic [DATA_W-1:0]  rx_wdata,
   input  logic               rx_pop,
   output logic [DATA_W-1:0]  rx_rdata,
   input  logic               rx_clr,
   input  logic               ovf_irq_clr,
   output logic [CNT_W-1:0]   tx_level,
   output logic [CNT_W-1:0]   rx_level,
   output logic [STATUS_W-1:0] status
);

   logic [CNT_W-1:0] eff_depth;
   logic             tx_empty, tx_afull, tx_full, tx_drop, tx_ovf;
   logic             rx_empty, rx_afull, rx_full, rx_drop, rx_ovf;
   logic             irq_q;
   awf_status_t      st;

   awf_depth_sel #(
      .FRAME_W(FRAME_W), .CNT_W(CNT_W), .PHYS_DEPTH(PHYS_DEPTH),
      .SHALLOW_DEPTH(SHALLOW_DEPTH), .NARROW_MAX(NARROW_MAX), .MID_MAX(MID_MAX),
      .NARROW_DEPTH(NARROW_DEPTH), .MID_DEPTH(MID_DEPTH), .WIDE_DEPTH(WIDE_DEPTH)
   ) u_depth (
      .deep_en(deep_en), .frame_bits(frame_bits), .depth(eff_depth)
   );

   awf_ring #(.DATA_W(DATA_W), .PHYS_DEPTH(PHYS_DEPTH), .TRACK_OVF(1'b0)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .depth(eff_depth),
      .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
      .level(tx_level), .empty(tx_empty), .afull(tx_afull), .full(tx_full),
      .drop(tx_drop), .ovf(tx_ovf)
   );

   awf_ring #(.DATA_W(DATA_W), .PHYS_DEPTH(PHYS_DEPTH), .TRACK_OVF(1'b1)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .depth(eff_depth),
      .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
      .level(rx_level), .empty(rx_empty), .afull(rx_afull), .full(rx_full),
      .drop(rx_drop), .ovf(rx_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           irq_q <= 1'b0;
      else if (rx_drop)     irq_q <= 1'b1;
      else if (ovf_irq_clr) irq_q <= 1'b0;
   end

   always_comb begin
      st          = '0;
      st.tx_empty = tx_empty;
      st.tx_afull = tx_afull;
      st.tx_full  = tx_full;
      st.rx_empty = rx_empty;
      st.rx_afull = rx_afull;
      st.rx_full  = rx_full;
      st.rx_ovf   = rx_ovf;
      st.ovf_irq  = irq_q;
   end
   assign status = st;

   // R3: a transmit drop only happens while the queue reports full
   p_tx_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_drop |-> (tx_full && !tx_ovf));
   // R6: a receive drop raises the interrupt bit next cycle
   p_rx_drop_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop |=> status[7]);
   // R7: the interrupt bit only falls after an explicit clear
   p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_q) |-> $past(ovf_irq_clr));

endmodule

// File: tb/adaptive_word_fifo_pair_tb.sv
module adaptive_word_fifo_pair_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        deep_en = 1'b0;
   logic [5:0]  frame_bits = 6'd8;
   logic        tx_push = 0, tx_pop = 0, tx_clr = 0;
   logic        rx_push = 0, rx_pop = 0, rx_clr = 0, ovf_irq_clr = 0;
   logic [31:0] tx_wdata = '0, rx_wdata = '0;
   logic [31:0] tx_rdata, rx_rdata;
   logic [5:0]  tx_level, rx_level;
   logic [7:0]  status;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   adaptive_word_fifo_pair u_dut (
      .clk(clk), .rst_n(rst_n), .deep_en(deep_en), .frame_bits(frame_bits),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .tx_clr(tx_clr), .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
      .rx_rdata(rx_rdata), .rx_clr(rx_clr), .ovf_irq_clr(ovf_irq_clr),
      .tx_level(tx_level), .rx_level(rx_level), .status(status)
   );

   // {deep_en, frame_bits, expected depth}
   localparam int NVEC = 8;
   localparam logic [12:0] VEC [NVEC] = '{
      {1'b0, 6'd4,  6'd4},  {1'b0, 6'd32, 6'd4},
      {1'b1, 6'd0,  6'd32}, {1'b1, 6'd8,  6'd32},
      {1'b1, 6'd9,  6'd16}, {1'b1, 6'd16, 6'd16},
      {1'b1, 6'd17, 6'd8},  {1'b1, 6'd32, 6'd8}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push_tx(input logic [31:0] d);
      tx_push = 1; tx_wdata = d; @(negedge clk); tx_push = 0;
   endtask
   task automatic push_rx(input logic [31:0] d);
      rx_push = 1; rx_wdata = d; @(negedge clk); rx_push = 0;
   endtask
   task automatic pop_tx(output logic [31:0] d);
      d = tx_rdata; tx_pop = 1; @(negedge clk); tx_pop = 0;
   endtask
   task automatic pop_rx(output logic [31:0] d);
      d = rx_rdata; rx_pop = 1; @(negedge clk); rx_pop = 0;
   endtask
   task automatic clear_both();
      tx_clr = 1; rx_clr = 1; @(negedge clk); tx_clr = 0; rx_clr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int dep;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 status", status, 32'h09);
      chk("R11 tx_level", tx_level, 0);
      chk("R11 rx_level", rx_level, 0);
      rst_n = 1;
      @(negedge clk);

      // table walk: R1 R2 R3 R4 R5
      for (int k = 0; k < NVEC; k++) begin
         deep_en = VEC[k][12]; frame_bits = VEC[k][11:6]; dep = int'(VEC[k][5:0]);
         clear_both();
         for (int i = 0; i < dep - 1; i++) push_tx(32'h100 * k + i);
         chk("R4 tx almost-full at depth-1", status[1], 1);
         chk("R4 tx not full at depth-1", status[2], 0);
         chk("R5 tx not empty after push", status[0], 0);
         push_tx(32'h100 * k + dep - 1);
         chk("R4 tx full at depth", status[2:1], 2'b10);
         push_tx(32'hDEAD0000 + k);
         push_tx(32'hBEEF0000 + k);
         chk(deep_en ? "R1 depth via tx_level" : "R2 depth via tx_level", tx_level, dep);
         for (int i = 0; i < dep; i++) begin
            pop_tx(d);
            chk("R3 order kept, dropped words absent", d, 32'h100 * k + i);
         end
         chk("R5 empty after last pop", status[0], 1);
         chk("R9 empty head reads zero", tx_rdata, 0);
      end

      // R9 pop on empty
      clear_both();
      pop_tx(d);
      chk("R9 empty pop data", d, 0);
      chk("R9 empty pop level", tx_level, 0);

      // R6 R7 receive overflow (shallow)
      deep_en = 0;
      for (int i = 0; i < 3; i++) push_rx(32'hA0 + i);
      chk("R4 rx almost-full", status[5:4], 2'b01);
      push_rx(32'hA3);
      chk("R4 rx full", status[5:4], 2'b10);
      chk("R6 no overflow yet", status[7:6], 2'b00);
      push_rx(32'hFFFF);
      chk("R6 overflow and irq set", status[7:6], 2'b11);
      chk("R6 level unchanged", rx_level, 4);
      pop_rx(d);
      chk("R6 first word kept", d, 32'hA0);
      chk("R7 read clears overflow, irq stays", status[7:6], 2'b10);
      ovf_irq_clr = 1; @(negedge clk); ovf_irq_clr = 0;
      chk("R7 irq cleared", status[7], 0);
      for (int i = 1; i < 4; i++) begin
         pop_rx(d);
         chk("R6 overflowed word discarded", d, 32'hA0 + i);
      end
      chk("R5 rx empty", status[3], 1);

      // R7 empty read clears overflow
      for (int i = 0; i < 5; i++) push_rx(i);
      clear_both();
      chk("R8 clear empties rx", rx_level, 0);
      chk("R8 clear flags", status[5:3], 3'b001);
      chk("R8 clear leaves overflow sticky", status[6], 1);
      pop_rx(d);
      chk("R7 empty read clears overflow", status[6], 0);
      ovf_irq_clr = 1; @(negedge clk); ovf_irq_clr = 0;

      // R8 clear wins over push
      push_tx(32'h1);
      tx_clr = 1; tx_push = 1; tx_wdata = 32'h2; @(negedge clk);
      tx_clr = 0; tx_push = 0;
      chk("R8 clear beats push", tx_level, 0);

      // R10 depth change keeps data
      deep_en = 1; frame_bits = 6'd8;
      for (int i = 0; i < 10; i++) push_tx(32'h500 + i);
      deep_en = 0;
      @(negedge clk);
      chk("R10 level kept after shrink", tx_level, 10);
      chk("R4 full when level exceeds depth", status[2:1], 2'b10);
      push_tx(32'hBAD);
      chk("R3 push dropped after shrink", tx_level, 10);
      for (int i = 0; i < 10; i++) begin
         pop_tx(d);
         chk("R10 order after depth change", d, 32'h500 + i);
      end
      chk("R5 empty after drain", status[0], 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule